// File: doc/BRIEF.md
# I2C Serial Memory Slave

This block lets an I2C master read and write a small byte-addressable memory held in flip-flops. The SCL and SDA lines come in as plain inputs; the block pulls SDA low through a single drive-enable output, and the board's open-drain wiring does the rest. The master first sends a slave address. If that address matches the one set by parameter, the block acknowledges it and then follows a write frame or a read frame, depending on the direction bit.

A write frame carries two address bytes and then any number of data bytes. Each data byte is stored at the address latch, and the latch then advances. A read frame carries no address. It returns bytes starting at the latch, so a read continues from the point where the previous operation stopped. To read from a chosen location, the master sends a write frame that holds only the two address bytes, then a repeated Start, then a read request. The latch is 10 bits wide, so addresses wrap from the top of the 1024-byte array back to zero. A byte being written is kept only after all eight of its bits have arrived. A read can be ended by several different master sequences, and after each of them the block lets go of SDA.

Top module: `i2c_mem_slave`

## Requirements
- R1: Both lines pass through two-flop synchronizers. A Start is SDA falling while SCL is high. A Stop is SDA rising while SCL is high. The cycle after either one, SDA is released. A Start then waits for a slave address, and a Stop goes idle.
- R2: The first byte after a Start is sent MSB first. Bits 7:1 are the 7-bit slave address and bit 0 is the direction (0 = write, 1 = read). On a match the block acknowledges by holding SDA low during the 9th clock. On a mismatch it does not acknowledge, never drives SDA, and ignores every byte up to the next Start.
- R3: In a write frame the first address byte holds address bits 15:8 and the second holds bits 7:0. Each data byte after them is acknowledged and stored at the latch, and the latch then increments by one.
- R4: A data byte is stored only once its 8th bit has been sampled. A Start or Stop before that leaves the memory unchanged, and the latch is not advanced for the partial byte.
- R5: Address bits above bit 9 are ignored, so address FC05h selects location 005h.
- R6: The latch wraps from 3FFh to 000h, for writes and for reads alike.
- R7: A read sends the byte at the latch MSB first and then increments the latch. Each master ACK (SDA low in the 9th clock) makes the block send the next byte.
- R8: A read with no address phase starts at the location right after the last one written or read by the previous operation.
- R9: A selective read has three parts: a write frame holding only the two address bytes, a repeated Start, then a read request. The first byte returned comes from the loaded address.
- R10: A read ends correctly on any of four sequences: NACK then Stop, NACK then Start, Stop in the 9th clock, or Start in the 9th clock. After each one SDA is released and the block accepts the next frame normally.
- R11: The block starts pulling SDA low only while the synchronized SCL is low.
- R12: After reset SDA is released, the latch is 000h and every memory byte is 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Level of the I2C clock line |
| sda_i | input | 1 | Level of the I2C data line |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Random bursts of one to four bytes at random 16-bit addresses are each written and then read back with a selective read. Because the upper address bits are random, this separates correct address truncation and latch stepping from an off-by-one or a stale latch. Current-address reads are mixed in with each of the four endings. These show whether the latch carries over between frames and whether SDA is released in every case. Directed cases cover the rest: a write cut short by a Stop or a Start after a few bits, the boundary at 3FFh, an address with its high bits set, a wrong slave address, and a read right after reset. Each of these isolates one rule that random traffic would rarely reach.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    // Bus events seen in the system clock domain after synchronization
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_IGNORE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_ACK,
        ST_RDAT,
        ST_RACK
    } state_t;

    localparam logic [3:0] BYTE_BITS = 4'd8;

    // Bit to put on the line after k bits of a byte have gone out (MSB first)
    function automatic logic pick_bit(input logic [7:0] b, input logic [3:0] k);
        logic [2:0] idx;
        idx = 3'(4'd7 - k);
        return b[idx];
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_mem_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);
    logic [STAGES-1:0] scl_p;
    logic [STAGES-1:0] sda_p;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            scl_q <= scl_p[STAGES-1];
            sda_q <= sda_p[STAGES-1];
        end
    end

    assign scl_s = scl_p[STAGES-1];
    assign sda_s = sda_p[STAGES-1];

    always_comb begin
        evt_o.scl_rise = scl_s & ~scl_q;
        evt_o.scl_fall = ~scl_s & scl_q;
        evt_o.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
        evt_o.sda      = sda_s;
    end
endmodule

// File: rtl/i2c_mem_regs.sv
module i2c_mem_regs #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'h00;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_mem_engine.sv
module i2c_mem_engine
    import i2c_mem_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h52,
    parameter int         AW       = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_evt_t      evt,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] ptr_o,
    output logic          wr_en_o,
    output logic [7:0]    wr_data_o,
    output logic          sda_pull_o,
    output logic          quiet_o
);
    localparam int            HI_W = AW - 8;
    localparam logic [AW-1:0] ONE  = 1;

    state_t            st;
    state_t            after;
    logic [7:0]        shreg;
    logic [7:0]        tx;
    logic [3:0]        bitcnt;
    logic [HI_W-1:0]   hi_q;
    logic              mack;
    logic              pull;
    logic [AW-1:0]     ptr;
    logic              addr_match;

    assign addr_match = (shreg[7:1] == DEV_ADDR);
    assign wr_en_o    = (st == ST_WDAT) && evt.scl_rise && (bitcnt == 4'd7);
    assign wr_data_o  = {shreg[6:0], evt.sda};
    assign ptr_o      = ptr;
    assign sda_pull_o = pull;
    assign quiet_o    = (st == ST_IDLE) || (st == ST_IGNORE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            after  <= ST_IDLE;
            shreg  <= 8'h00;
            tx     <= 8'h00;
            bitcnt <= 4'd0;
            hi_q   <= '0;
            mack   <= 1'b0;
            pull   <= 1'b0;
            ptr    <= '0;
        end else if (evt.start) begin
            st     <= ST_DEV;
            bitcnt <= 4'd0;
            pull   <= 1'b0;
        end else if (evt.stop) begin
            st     <= ST_IDLE;
            bitcnt <= 4'd0;
            pull   <= 1'b0;
        end else begin
            unique case (st)
                ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (evt.scl_rise && (bitcnt < BYTE_BITS)) begin
                        shreg  <= {shreg[6:0], evt.sda};
                        bitcnt <= bitcnt + 4'd1;
                        if (wr_en_o) begin
                            ptr <= ptr + ONE;
                        end
                    end else if (evt.scl_fall && (bitcnt == BYTE_BITS)) begin
                        bitcnt <= 4'd0;
                        pull   <= 1'b1;
                        st     <= ST_ACK;
                        case (st)
                            ST_DEV: begin
                                if (addr_match) begin
                                    after <= shreg[0] ? ST_RDAT : ST_AHI;
                                end else begin
                                    pull <= 1'b0;
                                    st   <= ST_IGNORE;
                                end
                            end
                            ST_AHI: begin
                                hi_q  <= shreg[HI_W-1:0];
                                after <= ST_ALO;
                            end
                            ST_ALO: begin
                                ptr   <= {hi_q, shreg};
                                after <= ST_WDAT;
                            end
                            default: after <= ST_WDAT;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (evt.scl_fall) begin
                        bitcnt <= 4'd0;
                        st     <= after;
                        if (after == ST_RDAT) begin
                            tx   <= rd_data;
                            pull <= ~rd_data[7];
                            ptr  <= ptr + ONE;
                        end else begin
                            pull <= 1'b0;
                        end
                    end
                end
                ST_RDAT: begin
                    if (evt.scl_rise && (bitcnt < BYTE_BITS)) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (evt.scl_fall) begin
                        if (bitcnt == BYTE_BITS) begin
                            pull <= 1'b0;
                            st   <= ST_RACK;
                        end else begin
                            pull <= ~pick_bit(tx, bitcnt);
                        end
                    end
                end
                ST_RACK: begin
                    if (evt.scl_rise) begin
                        mack <= ~evt.sda;
                    end else if (evt.scl_fall) begin
                        bitcnt <= 4'd0;
                        if (mack) begin
                            tx   <= rd_data;
                            pull <= ~rd_data[7];
                            ptr  <= ptr + ONE;
                            st   <= ST_RDAT;
                        end else begin
                            st <= ST_IGNORE;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h52,
    parameter int         MEM_BYTES   = 1024,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);
    localparam int AW = $clog2(MEM_BYTES);

    bus_evt_t      evt;
    logic [AW-1:0] ptr;
    logic          wr_en;
    logic [7:0]    wr_data;
    logic [7:0]    rd_data;
    logic          quiet;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    i2c_mem_engine #(.DEV_ADDR(DEV_ADDR), .AW(AW)) eng_i (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .rd_data    (rd_data),
        .ptr_o      (ptr),
        .wr_en_o    (wr_en),
        .wr_data_o  (wr_data),
        .sda_pull_o (sda_pull_o),
        .quiet_o    (quiet)
    );

    i2c_mem_regs #(.DEPTH(MEM_BYTES), .AW(AW)) regs_i (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (ptr),
        .wdata (wr_data),
        .raddr (ptr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk
    import i2c_mem_pkg::*;
#(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          scl_i,
    input bus_evt_t      evt,
    input logic          sda_pull,
    input logic          wr_en,
    input logic [AW-1:0] ptr,
    input logic          quiet
);
    localparam logic [AW-1:0] ONE = 1;

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> !sda_pull); // R1

    AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> !sda_pull); // R10

    AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_i); // R11

    AST_LATCH_STEPS_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ptr == $past(ptr) + ONE)); // R6

    AST_QUIET_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        quiet |-> !sda_pull); // R2
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.AW(AW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .evt      (evt),
    .sda_pull (sda_pull_o),
    .wr_en    (wr_en),
    .ptr      (ptr),
    .quiet    (quiet)
);

// File: tb/i2c_mem_slave_tb.sv
`timescale 1ns/1ps
module i2c_mem_slave_tb_top;
    localparam int         Q   = 6;
    localparam logic [6:0] DEV = 7'h52;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda_line;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    i2c_mem_slave dut_i (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    logic [7:0]  exp_mem [1024];
    logic [9:0]  exp_ptr = 10'h000;
    logic [7:0]  wbuf [8];
    logic        pull_d = 1'b0;

    function automatic logic [7:0] dev_byte(input logic [6:0] a, input logic rw);
        return {a, rw};
    endfunction

    function automatic logic [9:0] wrap_addr(input int a);
        return 10'(a);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R11: pull may only begin while SCL is low
    always @(posedge clk) begin
        if (!rst && sda_pull && !pull_d && scl_m) begin
            n_chk++;
            n_bad++;
            $display("FAIL R11 pull asserted with SCL high actual=1 expected=0");
        end
        pull_d <= sda_pull;
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_c();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic bit_tx(input logic b);
        sda_m = b;    wq(Q);
        scl_m = 1'b1; wq(Q);
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bit_rx(output logic b);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        b = sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_bits(input logic [7:0] v, input int k);
        for (int i = 0; i < k; i++) bit_tx(v[7-i]);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic b;
        send_bits(v, 8);
        bit_rx(b);
        acked = ~b;
    endtask

    task automatic recv8(output logic [7:0] v);
        logic b;
        for (int i = 0; i < 8; i++) begin
            bit_rx(b);
            v = {v[6:0], b};
        end
    endtask

    // Reads n bytes, ends with the chosen termination (1..4)
    task automatic read_run(input int n, input int term, input string tag);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            recv8(v);
            chk(tag, v, exp_mem[exp_ptr]);
            exp_ptr = exp_ptr + 10'd1;
            if (i < n - 1) bit_tx(1'b0);
            else begin
                case (term)
                    1: begin bit_tx(1'b1); stop_c(); end
                    2: begin bit_tx(1'b1); start_c(); stop_c(); end
                    3: stop_c();
                    default: begin start_c(); stop_c(); end
                endcase
            end
        end
        wq(4);
        chk($sformatf("R10 SDA released after ending %0d", term), sda_pull, 0);
    endtask

    task automatic wr_frame(input int addr, input int n, input string tag);
        logic a;
        start_c();
        send_byte(dev_byte(DEV, 1'b0), a);
        chk("R2 address ACK on write", a, 1);
        send_byte(addr[15:8], a);
        send_byte(addr[7:0], a);
        exp_ptr = wrap_addr(addr);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            chk({tag, " data ACK"}, a, 1);
            exp_mem[exp_ptr] = wbuf[i];
            exp_ptr = exp_ptr + 10'd1;
        end
        stop_c();
    endtask

    task automatic rd_sel(input int addr, input int n, input string tag);
        logic a;
        start_c();
        send_byte(dev_byte(DEV, 1'b0), a);
        send_byte(addr[15:8], a);
        send_byte(addr[7:0], a);
        exp_ptr = wrap_addr(addr);
        start_c();
        send_byte(dev_byte(DEV, 1'b1), a);
        chk("R2 address ACK on read", a, 1);
        read_run(n, 1, tag);
    endtask

    task automatic rd_cur(input int n, input int term, input string tag);
        logic a;
        start_c();
        send_byte(dev_byte(DEV, 1'b1), a);
        chk("R2 address ACK on current read", a, 1);
        read_run(n, term, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic       a;
        logic [7:0] v;
        int         addr;
        int         len;
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) exp_mem[i] = 8'h00;
        wq(10);
        rst = 1'b0;
        wq(4);

        // R12: reset state
        chk("R12 SDA released after reset", sda_pull, 0);
        rd_cur(2, 1, "R12 read from cleared memory at latch 0");

        // R3 burst write and R9 selective read back
        for (int i = 0; i < 6; i++) wbuf[i] = 8'(8'h30 + i * 7);
        wr_frame(16'h0040, 6, "R3 burst");
        rd_sel(16'h0040, 6, "R9 selective read of burst");
        rd_cur(2, 1, "R8 current read continues");

        // R4 abort by Stop mid-byte
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        wr_frame(16'h0130, 2, "R3 pre-fill");
        start_c();
        send_byte(dev_byte(DEV, 1'b0), a);
        send_byte(8'h01, a);
        send_byte(8'h30, a);
        send_byte(8'hA5, a);
        chk("R4 full byte ACK", a, 1);
        exp_mem[10'h130] = 8'hA5;
        send_bits(8'h3C, 5);
        stop_c();
        exp_ptr = 10'h131;
        rd_cur(1, 1, "R4 Stop abort keeps old byte");

        // R4 abort by Start mid-byte
        start_c();
        send_byte(dev_byte(DEV, 1'b0), a);
        send_byte(8'h01, a);
        send_byte(8'h30, a);
        send_bits(8'hC3, 3);
        start_c();
        stop_c();
        exp_ptr = 10'h130;
        rd_cur(2, 1, "R4 Start abort keeps memory");

        // R5 upper address bits ignored
        wbuf[0] = 8'h5A;
        wr_frame(16'hFC05, 1, "R5 write");
        rd_sel(16'h0005, 1, "R5 truncated address");

        // R6 wrap
        wbuf[0] = 8'hE1; wbuf[1] = 8'hE2; wbuf[2] = 8'hE3;
        wr_frame(16'h03FE, 3, "R6 write wrap");
        rd_sel(16'h03FE, 3, "R6 read across wrap");
        rd_cur(1, 1, "R6 latch after wrap");

        // R2 mismatched address: no ACK, bytes ignored
        start_c();
        send_byte(dev_byte(DEV ^ 7'h01, 1'b0), a);
        chk("R2 wrong address NACK", a, 0);
        send_byte(8'h00, a);
        chk("R2 ignored byte NACK", a, 0);
        send_byte(8'h40, a);
        send_byte(8'hEE, a);
        chk("R2 ignored data NACK", a, 0);
        stop_c();
        rd_cur(1, 1, "R2 latch untouched by foreign frame");
        rd_sel(16'h0040, 1, "R2 memory untouched by foreign frame");
        start_c();
        send_byte(dev_byte(DEV ^ 7'h10, 1'b1), a);
        chk("R2 wrong read address NACK", a, 0);
        recv8(v);
        chk("R2 no drive after mismatch", v, 8'hFF);
        bit_tx(1'b1);
        stop_c();

        // R7/R10 the four read endings, latch carried across (R8)
        rd_sel(16'h0040, 1, "R7 first byte");
        rd_cur(2, 2, "R10 NACK then Start");
        rd_cur(1, 3, "R10 Stop in 9th clock");
        rd_cur(2, 4, "R10 Start in 9th clock");
        rd_cur(1, 1, "R8 after Start ending");

        // Random bursts
        for (int it = 0; it < 12; it++) begin
            addr = int'($urandom() & 32'hFFFF);
            len  = 1 + int'($urandom() % 4);
            for (int i = 0; i < len; i++) wbuf[i] = 8'($urandom());
            wr_frame(addr, len, "R3 random write");
            rd_cur(1, 1 + int'($urandom() % 4), "R8 read after random write");
            rd_sel(addr, len, "R9 random read back");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule